// File: doc/BRIEF.md
# Ring-Shared Descriptor Job Dispatcher

This block hands out per-feature descriptor jobs to the scalar workers of four clusters, each holding eight workers. At the start of a tile every cluster reports how many features it detected. A cluster first fills its own workers with its own features. Workers it does not need are lent to the clusters next to it on a ring, so a busy cluster can use an idle neighbour's workers in the same round instead of waiting for another pass of its own workers.

Lending follows a fixed order. After local demand is met, free workers go to the clockwise neighbour first and then to the counter-clockwise neighbour. Every job carries the ID of the cluster that owns the feature and the feature's index, so results can be routed back to that cluster. A round runs in one clock cycle. If features are still unassigned when a round ends, the cluster's stall flag is raised and the next round starts on the following edge, continuing from the next unserved index. New tile requests are refused until every feature of the current tile has been assigned.

Top module: `wsd_dispatch`

## Requirements
- R1: After reset, every job_vld_o bit is 0, stall_o is all zero and busy_o is low.
- R2: A high go_i at a rising edge with busy_o low loads the per-cluster feature counts from nf_i. The count of cluster c is at bits c*FW and is FW bits wide. The jobs of the first round appear on the outputs right after that edge. At an edge with go_i low and busy_o low, all job_vld_o bits go to 0.
- R3: Worker w of cluster c is slot c*NW+w. The first min(remaining, NW) slots of cluster c take its own features, with source c and ascending indices.
- R4: Slots that cluster d has left after its local jobs go first to cluster (d+1) mod NCL, placed right after the local slots. The number lent is capped by that cluster's unmet demand.
- R5: Free slots still left after R4 go to cluster (d+NCL-1) mod NCL. The receiver's demand is counted after the lending of R4.
- R6: A job's source ID is CLW bits at (c*NW+w)*CLW of job_src_o, and its feature index is FW bits at (c*NW+w)*FW of job_idx_o. The indices of one cluster continue from its next unserved feature in this order: local jobs, then jobs placed at its counter-clockwise neighbour, then jobs placed at its clockwise neighbour.
- R7: stall_o[c] is high alongside a round's jobs exactly when cluster c still has unassigned features after that round. The next round then runs at the following edge and continues the indices.
- R8: busy_o is high while any feature remains unassigned. A go_i that arrives while busy_o is high is ignored.
- R9: A job is placed only in its own cluster or in a ring neighbour of that cluster. A cluster whose stall flag is high lends no worker in that round.
- R10: Within a cluster, the valid slots are contiguous starting at slot 0. Unused slots show vld 0, source 0 and index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| go_i | input | 1 | request to start a tile with the counts on nf_i |
| nf_i | input | NCL*FW | feature count per cluster |
| busy_o | output | 1 | features of the current tile remain |
| stall_o | output | NCL | per cluster, features left after this round |
| job_vld_o | output | NCL*NW | slot holds a job this round |
| job_src_o | output | NCL*NW*CLW | owning cluster of each slot's job |
| job_idx_o | output | NCL*NW*FW | feature index of each slot's job |

## Verification
Two things can happen in the same cycle. First, one donor's free workers can be wanted by both of its neighbours in one round. The tile counts are set so that each neighbour's overflow alone would fit the donor's free workers, but both together do not. The clockwise neighbour must then be served in full and the counter-clockwise one must get only what is left. Second, a stalled continuation round can meet a new go_i. A fresh request is sent while a stall is pending, and the jobs in the next cycle must still be the old tile's leftovers. The bench's behavioural model, which pops features from per-cluster pending counters phase by phase, judges every cycle. Directed checks pin the exact slots in both cases.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

  // smaller of two counts
  function automatic int unsigned lesser(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // clockwise ring neighbour
  function automatic int unsigned cw_of(input int unsigned c, input int unsigned n);
    return (c + 1) % n;
  endfunction

  // counter-clockwise ring neighbour
  function automatic int unsigned ccw_of(input int unsigned c, input int unsigned n);
    return (c + n - 1) % n;
  endfunction

endpackage

// File: rtl/wsd_lend.sv
module wsd_lend
  import wsd_pkg::*;
#(
  parameter int unsigned NCL = 4,
  parameter int unsigned NW  = 8,
  parameter int unsigned FW  = 8
) (
  input  logic [NCL-1:0][FW-1:0] rem_i,
  output logic [NCL-1:0][FW-1:0] loc_o,
  output logic [NCL-1:0][FW-1:0] gcw_o,
  output logic [NCL-1:0][FW-1:0] gccw_o,
  output logic [NCL-1:0][FW-1:0] offcw_o,
  output logic [NCL-1:0][FW-1:0] offccw_o,
  output logic [NCL-1:0][FW-1:0] served_o
);

  int unsigned loc_w  [NCL];
  int unsigned fre_w  [NCL];
  int unsigned nd_w   [NCL];
  int unsigned g1_w   [NCL];
  int unsigned nd2_w  [NCL];
  int unsigned fre2_w [NCL];
  int unsigned g2_w   [NCL];

  always_comb begin
    // phase 0: local demand
    for (int unsigned c = 0; c < NCL; c++) begin
      loc_w[c] = lesser(32'(rem_i[c]), NW);
      fre_w[c] = NW - loc_w[c];
      nd_w[c]  = 32'(rem_i[c]) - loc_w[c];
    end
    // phase 1: lend clockwise
    for (int unsigned c = 0; c < NCL; c++) begin
      g1_w[c] = lesser(fre_w[c], nd_w[cw_of(c, NCL)]);
    end
    for (int unsigned c = 0; c < NCL; c++) begin
      nd2_w[c]  = nd_w[c] - g1_w[ccw_of(c, NCL)];
      fre2_w[c] = fre_w[c] - g1_w[c];
    end
    // phase 2: lend counter-clockwise
    for (int unsigned c = 0; c < NCL; c++) begin
      g2_w[c] = lesser(fre2_w[c], nd2_w[ccw_of(c, NCL)]);
    end
    for (int unsigned c = 0; c < NCL; c++) begin
      loc_o[c]    = FW'(loc_w[c]);
      gcw_o[c]    = FW'(g1_w[c]);
      gccw_o[c]   = FW'(g2_w[c]);
      offcw_o[c]  = FW'(loc_w[cw_of(c, NCL)]);
      offccw_o[c] = FW'(loc_w[ccw_of(c, NCL)] + g1_w[ccw_of(ccw_of(c, NCL), NCL)]);
      served_o[c] = FW'(loc_w[c] + g1_w[ccw_of(c, NCL)] + g2_w[cw_of(c, NCL)]);
    end
  end

endmodule

// File: rtl/wsd_slot.sv
module wsd_slot
  import wsd_pkg::*;
#(
  parameter int unsigned NCL = 4,
  parameter int unsigned NW  = 8,
  parameter int unsigned FW  = 8,
  parameter int unsigned CLW = 2,
  parameter int unsigned CID = 0
) (
  input  logic [FW-1:0]           loc_i,
  input  logic [FW-1:0]           gcw_i,
  input  logic [FW-1:0]           gccw_i,
  input  logic [FW-1:0]           own_base_i,
  input  logic [FW-1:0]           cw_base_i,
  input  logic [FW-1:0]           ccw_base_i,
  output logic [NW-1:0]           vld_o,
  output logic [NW-1:0][CLW-1:0]  src_o,
  output logic [NW-1:0][FW-1:0]   idx_o
);

  localparam logic [CLW-1:0] OWN_ID = CLW'(CID);
  localparam logic [CLW-1:0] CW_ID  = CLW'(cw_of(CID, NCL));
  localparam logic [CLW-1:0] CCW_ID = CLW'(ccw_of(CID, NCL));

  logic [FW-1:0] end_loc;
  logic [FW-1:0] end_cw;
  logic [FW-1:0] end_ccw;

  assign end_loc = loc_i;
  assign end_cw  = loc_i + gcw_i;
  assign end_ccw = loc_i + gcw_i + gccw_i;

  for (genvar w = 0; w < NW; w++) begin : g_wk
    localparam logic [FW-1:0] POS = FW'(w);
    always_comb begin
      vld_o[w] = 1'b0;
      src_o[w] = '0;
      idx_o[w] = '0;
      if (POS < end_loc) begin
        vld_o[w] = 1'b1;
        src_o[w] = OWN_ID;
        idx_o[w] = own_base_i + POS;
      end else if (POS < end_cw) begin
        vld_o[w] = 1'b1;
        src_o[w] = CW_ID;
        idx_o[w] = cw_base_i + (POS - end_loc);
      end else if (POS < end_ccw) begin
        vld_o[w] = 1'b1;
        src_o[w] = CCW_ID;
        idx_o[w] = ccw_base_i + (POS - end_cw);
      end
    end
  end

endmodule

// File: rtl/wsd_dispatch.sv
module wsd_dispatch
  import wsd_pkg::*;
#(
  parameter int unsigned NCL = 4,
  parameter int unsigned NW  = 8,
  parameter int unsigned FW  = 8,
  localparam int unsigned CLW = (NCL > 1) ? $clog2(NCL) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   go_i,
  input  logic [NCL*FW-1:0]      nf_i,
  output logic                   busy_o,
  output logic [NCL-1:0]         stall_o,
  output logic [NCL*NW-1:0]      job_vld_o,
  output logic [NCL*NW*CLW-1:0]  job_src_o,
  output logic [NCL*NW*FW-1:0]   job_idx_o
);

  logic [NCL-1:0][FW-1:0] rem_q, base_q;
  logic [NCL-1:0][FW-1:0] src_rem, src_base;
  logic [NCL-1:0][FW-1:0] loc_w, gcw_w, gccw_w, offcw_w, offccw_w, served_w;
  logic [NCL-1:0][FW-1:0] rem_nxt, base_nxt, cwb_w, ccwb_w;
  logic [NCL-1:0][NW-1:0]          slot_vld;
  logic [NCL-1:0][NW-1:0][CLW-1:0] slot_src;
  logic [NCL-1:0][NW-1:0][FW-1:0]  slot_idx;
  logic [NCL-1:0]                  left_w;
  logic accept_w, run_w;

  assign busy_o   = |rem_q;
  assign accept_w = go_i & ~busy_o;
  assign run_w    = accept_w | busy_o;
  assign src_rem  = accept_w ? nf_i : rem_q;
  assign src_base = accept_w ? '0 : base_q;

  wsd_lend #(.NCL(NCL), .NW(NW), .FW(FW)) i_lend (
    .rem_i   (src_rem),
    .loc_o   (loc_w),
    .gcw_o   (gcw_w),
    .gccw_o  (gccw_w),
    .offcw_o (offcw_w),
    .offccw_o(offccw_w),
    .served_o(served_w)
  );

  for (genvar c = 0; c < NCL; c++) begin : g_cl
    localparam int unsigned CWN  = cw_of(c, NCL);
    localparam int unsigned CCWN = ccw_of(c, NCL);
    assign cwb_w[c]    = src_base[CWN] + offcw_w[c];
    assign ccwb_w[c]   = src_base[CCWN] + offccw_w[c];
    assign rem_nxt[c]  = src_rem[c] - served_w[c];
    assign base_nxt[c] = src_base[c] + served_w[c];
    assign left_w[c]   = (rem_nxt[c] != '0);

    wsd_slot #(.NCL(NCL), .NW(NW), .FW(FW), .CLW(CLW), .CID(c)) i_slot (
      .loc_i     (loc_w[c]),
      .gcw_i     (gcw_w[c]),
      .gccw_i    (gccw_w[c]),
      .own_base_i(src_base[c]),
      .cw_base_i (cwb_w[c]),
      .ccw_base_i(ccwb_w[c]),
      .vld_o     (slot_vld[c]),
      .src_o     (slot_src[c]),
      .idx_o     (slot_idx[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q     <= '0;
      base_q    <= '0;
      stall_o   <= '0;
      job_vld_o <= '0;
      job_src_o <= '0;
      job_idx_o <= '0;
    end else if (run_w) begin
      rem_q     <= rem_nxt;
      base_q    <= base_nxt;
      stall_o   <= left_w;
      job_vld_o <= slot_vld;
      job_src_o <= slot_src;
      job_idx_o <= slot_idx;
    end else begin
      stall_o   <= '0;
      job_vld_o <= '0;
      job_src_o <= '0;
      job_idx_o <= '0;
    end
  end

endmodule

// File: rtl/wsd_dispatch_chk.sv
module wsd_dispatch_chk
  import wsd_pkg::*;
#(
  parameter int unsigned NCL = 4,
  parameter int unsigned NW  = 8,
  parameter int unsigned CLW = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  go_i,
  input logic                  busy_o,
  input logic [NCL-1:0]        stall_o,
  input logic [NCL*NW-1:0]     job_vld_o,
  input logic [NCL*NW*CLW-1:0] job_src_o
);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!go_i && !busy_o) |=> (job_vld_o == '0));

  // R7
  stall_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o != '0) |-> busy_o);

  for (genvar d = 0; d < NCL; d++) begin : g_d
    localparam logic [CLW-1:0] OWN_ID = CLW'(d);
    localparam logic [CLW-1:0] CW_ID  = CLW'(cw_of(d, NCL));
    localparam logic [CLW-1:0] CCW_ID = CLW'(ccw_of(d, NCL));
    for (genvar w = 0; w < NW; w++) begin : g_w
      logic [CLW-1:0] s_w;
      logic           v_w;
      assign s_w = job_src_o[(d*NW+w)*CLW +: CLW];
      assign v_w = job_vld_o[d*NW+w];

      // R9
      ring_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_w |-> (s_w == OWN_ID || s_w == CW_ID || s_w == CCW_ID));

      // R9
      lender_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (v_w && s_w != OWN_ID) |-> !stall_o[d]);

      // R3
      stall_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o[d] |-> (v_w && s_w == OWN_ID));

      if (w > 0) begin : g_fill
        // R10
        fill_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          v_w |-> job_vld_o[d*NW+w-1]);
      end
    end
  end

endmodule

bind wsd_dispatch wsd_dispatch_chk #(.NCL(NCL), .NW(NW), .CLW(CLW)) i_wsd_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .go_i     (go_i),
  .busy_o   (busy_o),
  .stall_o  (stall_o),
  .job_vld_o(job_vld_o),
  .job_src_o(job_src_o)
);

// File: tb/test_wsd_dispatch.sv
module test_wsd_dispatch;

  localparam int NCL = 4;
  localparam int NW  = 8;
  localparam int FW  = 8;
  localparam int CLW = 2;
  localparam int NS  = NCL * NW;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  go_i = 1'b0;
  logic [NCL*FW-1:0]     nf_i = '0;
  logic                  busy_o;
  logic [NCL-1:0]        stall_o;
  logic [NS-1:0]         job_vld_o;
  logic [NS*CLW-1:0]     job_src_o;
  logic [NS*FW-1:0]      job_idx_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #5 clk_i = ~clk_i;

  wsd_dispatch #(.NCL(NCL), .NW(NW), .FW(FW)) i_wsd_dispatch (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go_i), .nf_i(nf_i),
    .busy_o(busy_o), .stall_o(stall_o), .job_vld_o(job_vld_o),
    .job_src_o(job_src_o), .job_idx_o(job_idx_o)
  );

  // behavioural model: pending range [nx_m, tot_m) per cluster
  int            tot_m [NCL];
  int            nx_m  [NCL];
  logic [NS-1:0]     e_vld;
  logic [NS*CLW-1:0] e_src;
  logic [NS*FW-1:0]  e_idx;
  logic [NCL-1:0]    e_stall;
  logic              e_busy;

  initial begin
    for (int c = 0; c < NCL; c++) begin tot_m[c] = 0; nx_m[c] = 0; end
    e_vld = '0; e_src = '0; e_idx = '0; e_stall = '0; e_busy = 1'b0;
  end

  function automatic bit pending_any();
    for (int c = 0; c < NCL; c++) if (nx_m[c] < tot_m[c]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk_i) begin
    int used [NCL];
    bit was_busy, run;
    if (!rst_ni) begin
      for (int c = 0; c < NCL; c++) begin tot_m[c] = 0; nx_m[c] = 0; end
      e_vld = '0; e_src = '0; e_idx = '0; e_stall = '0; e_busy = 1'b0;
    end else begin
      was_busy = pending_any();
      if (go_i && !was_busy) begin
        for (int c = 0; c < NCL; c++) begin
          tot_m[c] = int'(nf_i[c*FW +: FW]);
          nx_m[c]  = 0;
        end
      end
      run = go_i || was_busy;
      e_vld = '0; e_src = '0; e_idx = '0; e_stall = '0;
      if (run) begin
        for (int c = 0; c < NCL; c++) used[c] = 0;
        for (int ph = 0; ph < 3; ph++) begin
          for (int d = 0; d < NCL; d++) begin
            int r;
            r = (ph == 0) ? d : (ph == 1) ? (d + 1) % NCL : (d + NCL - 1) % NCL;
            while (used[d] < NW && nx_m[r] < tot_m[r]) begin
              int s;
              s = d * NW + used[d];
              e_vld[s] = 1'b1;
              e_src[s*CLW +: CLW] = CLW'(r);
              e_idx[s*FW +: FW]   = FW'(nx_m[r]);
              nx_m[r]++;
              used[d]++;
            end
          end
        end
        for (int c = 0; c < NCL; c++) e_stall[c] = (nx_m[c] < tot_m[c]);
      end
      e_busy = pending_any();
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      total++;
      if (job_vld_o !== e_vld || job_src_o !== e_src || job_idx_o !== e_idx) begin
        bad++;
        $display("FAIL R6 jobs at cycle %0d: actual vld=%h src=%h idx=%h expected vld=%h src=%h idx=%h",
                 cyc, job_vld_o, job_src_o, job_idx_o, e_vld, e_src, e_idx);
      end
      total++;
      if (stall_o !== e_stall) begin
        bad++;
        $display("FAIL R7 stall at cycle %0d: actual=%b expected=%b", cyc, stall_o, e_stall);
      end
      total++;
      if (busy_o !== e_busy) begin
        bad++;
        $display("FAIL R8 busy at cycle %0d: actual=%b expected=%b", cyc, busy_o, e_busy);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int s_vld(int c, int w); return int'(job_vld_o[c*NW+w]); endfunction
  function automatic int s_src(int c, int w); return int'(job_src_o[(c*NW+w)*CLW +: CLW]); endfunction
  function automatic int s_idx(int c, int w); return int'(job_idx_o[(c*NW+w)*FW +: FW]); endfunction

  task automatic set_nf(input int a, input int b, input int c, input int d);
    nf_i = {FW'(d), FW'(c), FW'(b), FW'(a)};
  endtask

  // drive go for one edge; returns at the negedge after it
  task automatic launch(input int a, input int b, input int c, input int d);
    set_nf(a, b, c, d);
    go_i = 1'b1;
    @(negedge clk_i);
    go_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL R8 watchdog: actual cycles=%0d expected below 100000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 vld", int'(job_vld_o != '0), 0);
    chk("R1 stall", int'(stall_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 clockwise lending: c0=2, c1=14
    launch(2, 14, 0, 0);
    chk("R3 c1 slot0 src", s_src(1, 0), 1);
    chk("R4 c0 slot2 src", s_src(0, 2), 1);
    chk("R4 c0 slot2 idx", s_idx(0, 2), 8);
    chk("R4 c0 slot7 idx", s_idx(0, 7), 13);
    chk("R7 no stall", int'(stall_o), 0);
    @(negedge clk_i);
    // R2 idle clears jobs
    chk("R2 idle vld", int'(job_vld_o != '0), 0);

    // R5 counter-clockwise lending: c0=12 c1=3 c2=5 c3=8
    launch(12, 3, 5, 8);
    chk("R5 c1 slot3 src", s_src(1, 3), 0);
    chk("R5 c1 slot3 idx", s_idx(1, 3), 8);
    chk("R6 c1 slot6 idx", s_idx(1, 6), 11);
    chk("R10 c1 slot7 vld", s_vld(1, 7), 0);
    @(negedge clk_i);

    // R5 priority: c0 has 4 free, both neighbours want 3
    launch(4, 11, 8, 11);
    chk("R4 c0 slot4 src", s_src(0, 4), 1);
    chk("R4 c0 slot6 idx", s_idx(0, 6), 10);
    chk("R5 c0 slot7 src", s_src(0, 7), 3);
    chk("R5 c0 slot7 idx", s_idx(0, 7), 8);
    chk("R7 stall c3", int'(stall_o[3]), 1);
    chk("R7 stall c1", int'(stall_o[1]), 0);
    chk("R8 busy", int'(busy_o), 1);
    // R8 new request while busy must be ignored
    launch(20, 20, 20, 20);
    chk("R8 ignored c3 slot0 idx", s_idx(3, 0), 9);
    chk("R8 ignored c3 slot1 idx", s_idx(3, 1), 10);
    chk("R8 ignored c3 slot2 vld", s_vld(3, 2), 0);
    chk("R8 ignored c0 vld", s_vld(0, 0), 0);
    chk("R8 busy dropped", int'(busy_o), 0);
    @(negedge clk_i);

    // R7 multi-round: c0=30 alone
    launch(30, 0, 0, 0);
    chk("R4 c3 slot0 src", s_src(3, 0), 0);
    chk("R4 c3 slot0 idx", s_idx(3, 0), 8);
    chk("R5 c1 slot0 idx", s_idx(1, 0), 16);
    chk("R7 stall c0", int'(stall_o[0]), 1);
    @(negedge clk_i);
    chk("R7 round2 c0 slot5 idx", s_idx(0, 5), 29);
    chk("R10 round2 c0 slot6 vld", s_vld(0, 6), 0);
    chk("R7 round2 stall", int'(stall_o), 0);
    @(negedge clk_i);

    // random tiles, judged by the model every cycle
    for (int t = 0; t < 300; t++) begin
      launch($urandom_range(40), $urandom_range(40), $urandom_range(40), $urandom_range(40));
      while (busy_o) @(negedge clk_i);
      if ((t % 3) == 0) @(negedge clk_i);
    end
    @(negedge clk_i);
    finish_run();
  end

endmodule